// File: doc/BRIEF.md
# Serial Receive Buffer with Fill Trigger

This block sits between a serial receiver and the CPU-facing register file of a serial port. The receiver presents each finished byte with a one-cycle strobe. The block keeps up to 16 bytes in a circular store. The CPU takes the oldest byte through a data-register read strobe and can see how many bytes are waiting at any time.

A FIFO control write does two jobs. It selects one of four fill thresholds from a two-bit code, and it can flush the store. When the fill level reaches the threshold, a sticky data-full flag is raised. If receive interrupts are enabled, an interrupt request is raised as well. Pops that bring the level below the threshold clear both. The receive-enable and interrupt-enable bits come from the serial control register, which is held outside this block, and arrive as level inputs.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: After reset, occ_count is 0, data_full and rx_irq are 0, rd_data reads 8'hFF, and the threshold code is 00, so the threshold is 1 entry.
- R2: A strobe on rx_valid while rx_en is 1 stores rx_byte. rd_data always shows the oldest stored byte. A pop_rd strobe removes that byte. occ_count shows the number of stored bytes from the clock edge that follows each change.
- R3: A strobe on rx_valid that arrives when 16 bytes are already stored is discarded, and the stored contents and count do not change.
- R4: A strobe on rx_valid while rx_en is 0 is ignored.
- R5: A write on cfg_wr stores cfg_wdata bits 7:6 as the threshold code: 00 selects 1 entry, 01 selects 4, 10 selects 8 and 11 selects 14. A new code is used from the next cycle onward.
- R6: After an accepted byte, data_full is set if the new count is at or above the threshold.
- R7: After a pop, data_full is cleared if the new count is below the threshold. Otherwise data_full holds its value, and a change of threshold alone does not re-evaluate it.
- R8: rx_irq is set together with data_full on an accepted byte, but only while irq_en is 1. rx_irq is cleared on the edge after irq_en is 0, and whenever data_full is cleared.
- R9: A cfg_wr with cfg_wdata bit 1 set empties the store and clears data_full and rx_irq. It takes precedence over a push or a pop in the same cycle.
- R10: While the store is empty, rd_data reads 8'hFF and a pop_rd strobe changes nothing.
- R11: An accepted push and a pop in the same cycle leave the count unchanged and advance both ends of the queue.
- R12: Both ends of the queue wrap from entry 15 back to entry 0, and byte order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_en | input | 1 | Receive enable from the serial control register |
| irq_en | input | 1 | Receive interrupt enable from the serial control register |
| cfg_wr | input | 1 | Write strobe for the FIFO control register |
| cfg_wdata | input | 8 | Control data: bits 7:6 select the threshold, bit 1 flushes |
| pop_rd | input | 1 | Data-register read strobe, removes the oldest byte |
| rd_data | output | 8 | Oldest stored byte, or 8'hFF when empty |
| occ_count | output | 5 | Number of stored bytes |
| data_full | output | 1 | Sticky flag: the fill level reached the threshold |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
All state changes land on the clock edge that samples the strobe, so occ_count, data_full and rx_irq are due one edge after the stimulus. rd_data is combinational from the stored state and is already valid in the cycle after that edge. The bench drives each stimulus on a falling edge and checks rd_data one nanosecond later, before the rising edge consumes the byte. It then waits for the following falling edge and compares count, flag and interrupt against a queue model that it has advanced by exactly one step. A threshold sweep over all four codes, the edge cases and a long pseudo-random mix all use this same stepping.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Fill threshold selected by the two-bit code, scaled to the store depth.
   // For a 16-entry store this yields 1, 4, 8 and 14.
   function automatic int unsigned thr_of(input logic [1:0] code, input int unsigned depth);
      case (code)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - 2;
      endcase
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned PW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              flush,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [CW-1:0]     count
);
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic [DATA_W-1:0] mem [DEPTH];

   // one register per entry; pointers wrap by natural overflow (DEPTH is 2**PW)
   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (push && (wr_ptr == PW'(i)))
            mem[i] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[rd_ptr];
endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_code,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [CW-1:0] new_count,
   input  logic          irq_en,
   output logic          data_full,
   output logic          rx_irq
);
   import rxq_pkg::*;

   logic [1:0]    code_q;
   logic [CW-1:0] thr;
   logic          set_ev, clr_ev;

   assign thr    = CW'(thr_of(code_q, DEPTH));
   assign set_ev = push && (new_count >= thr);
   assign clr_ev = pop  && (new_count <  thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q    <= 2'd0;
         data_full <= 1'b0;
         rx_irq    <= 1'b0;
      end else begin
         if (cfg_wr) code_q <= cfg_code;

         if (flush)       data_full <= 1'b0;
         else if (set_ev) data_full <= 1'b1;
         else if (clr_ev) data_full <= 1'b0;

         if (flush || !irq_en) rx_irq <= 1'b0;
         else if (set_ev)      rx_irq <= 1'b1;
         else if (clr_ev)      rx_irq <= 1'b0;
      end
   end
endmodule

// File: rtl/rxq_trigger_fifo.sv
module rxq_trigger_fifo #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_en,
   input  logic              irq_en,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   input  logic              pop_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     occ_count,
   output logic              data_full,
   output logic              rx_irq
);
   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rxq_trigger_fifo: DEPTH must be a power of two of at least 8");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rxq_trigger_fifo: DATA_W must be positive");
   end

   logic              flush, push_ok, pop_ok;
   logic [DATA_W-1:0] head;
   logic [CW-1:0]     next_count;

   assign flush   = cfg_wr && cfg_wdata[1];
   assign push_ok = rx_valid && rx_en && !flush && (occ_count != CW'(DEPTH));
   assign pop_ok  = pop_rd && !flush && (occ_count != '0);

   always_comb begin
      next_count = occ_count;
      if (push_ok && !pop_ok) next_count = occ_count + 1'b1;
      if (pop_ok && !push_ok) next_count = occ_count - 1'b1;
   end

   rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_ok),
      .pop   (pop_ok),
      .flush (flush),
      .din   (rx_byte),
      .dout  (head),
      .count (occ_count)
   );

   rxq_thresh #(.DEPTH(DEPTH)) thresh_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_code  (cfg_wdata[7:6]),
      .flush     (flush),
      .push      (push_ok),
      .pop       (pop_ok),
      .new_count (next_count),
      .irq_en    (irq_en),
      .data_full (data_full),
      .rx_irq    (rx_irq)
   );

   assign rd_data = (occ_count == '0) ? '1 : head;
endmodule

// File: rtl/rxq_trigger_fifo_chk.sv
module rxq_trigger_fifo_chk #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_en,
   input logic              irq_en,
   input logic              cfg_wr,
   input logic [7:0]        cfg_wdata,
   input logic              pop_rd,
   input logic [DATA_W-1:0] rd_data,
   input logic [CW-1:0]     occ_count,
   input logic              data_full,
   input logic              rx_irq
);
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      occ_count <= CW'(DEPTH));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_count == CW'(DEPTH) && !pop_rd && !cfg_wr) |=> (occ_count == CW'(DEPTH)));

   assert_rx_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !pop_rd && !cfg_wr) |=> $stable(occ_count));

   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !rx_irq);

   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> data_full);

   assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[1]) |=> (occ_count == '0 && !data_full && !rx_irq));

   assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_count == '0) |-> (rd_data == '1));

   assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_en && pop_rd && !cfg_wr && occ_count != '0 && occ_count != CW'(DEPTH))
      |=> $stable(occ_count));
endmodule

bind rxq_trigger_fifo rxq_trigger_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_en     (rx_en),
   .irq_en    (irq_en),
   .cfg_wr    (cfg_wr),
   .cfg_wdata (cfg_wdata),
   .pop_rd    (pop_rd),
   .rd_data   (rd_data),
   .occ_count (occ_count),
   .data_full (data_full),
   .rx_irq    (rx_irq)
);

// File: tb/rxq_trigger_fifo_tb_top.sv
module rxq_trigger_fifo_tb_top;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_en = 1'b0;
   logic       irq_en = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       pop_rd = 1'b0;
   logic [7:0] rd_data;
   logic [4:0] occ_count;
   logic       data_full;
   logic       rx_irq;

   int unsigned vecs = 0;
   int unsigned bad  = 0;

   logic [7:0] mq[$];
   bit         m_full = 0;
   bit         m_irq  = 0;
   int         m_thr  = 1;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;   // 125 MHz

   rxq_trigger_fifo #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_en(rx_en), .irq_en(irq_en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .pop_rd(pop_rd), .rd_data(rd_data), .occ_count(occ_count),
      .data_full(data_full), .rx_irq(rx_irq)
   );

   // R5: threshold by code 00/01/10/11 -> 1/4/8/14
   function automatic int thr_code(input logic [1:0] c);
      case (c)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Called positioned at a falling edge. Drives one cycle, checks rd_data
   // before the consuming edge, then checks registered results one edge later.
   task automatic step(input bit v, input logic [7:0] d, input bit en, input bit ie,
                       input bit pop, input bit cw, input logic [7:0] cd, input string tag);
      bit fl, pd, ud, se, ce;
      int n, told;
      rx_valid = v; rx_byte = d; rx_en = en; irq_en = ie;
      pop_rd = pop; cfg_wr = cw; cfg_wdata = cd;
      #1;
      if (mq.size() > 0) chk("R2", "rd_data", rd_data, mq[0]);
      else               chk("R10", "rd_data(empty)", rd_data, 8'hFF);
      @(posedge clk);
      told = m_thr;
      fl = cw && cd[1];
      if (fl) begin
         mq.delete(); m_full = 0; m_irq = 0;
      end else begin
         pd = pop && (mq.size() > 0);
         ud = v && en && (mq.size() < DEPTH);
         if (pd) void'(mq.pop_front());
         if (ud) mq.push_back(d);
         n  = mq.size();
         se = ud && (n >= told);
         ce = pd && (n < told);
         if (se) m_full = 1; else if (ce) m_full = 0;
         if (!ie) m_irq = 0; else if (se) m_irq = 1; else if (ce) m_irq = 0;
      end
      if (cw) m_thr = thr_code(cd[7:6]);
      @(negedge clk);
      chk(tag, "occ_count", occ_count, mq.size());
      chk("R6", "data_full", data_full, m_full);
      chk("R8", "rx_irq", rx_irq, m_irq);
   endtask

   task automatic idle();
      step(0, 8'h00, 1, 1, 0, 0, 8'h00, "R2");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "occ_count", occ_count, 0);
      chk("R1", "data_full", data_full, 0);
      chk("R1", "rx_irq", rx_irq, 0);
      chk("R1", "rd_data", rd_data, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: default threshold of one -> first byte raises the flag
      step(1, 8'h5A, 1, 1, 0, 0, 8'h00, "R1");
      chk("R1", "flag at threshold 1", data_full, 1);
      step(0, 8'h00, 1, 1, 1, 0, 8'h00, "R7");
      chk("R7", "flag after drain", data_full, 0);

      // R3: fill to 16, then two extra bytes are dropped
      for (int i = 0; i < 18; i++) step(1, 8'(8'h10 + i), 1, 1, 0, 0, 8'h00, "R3");
      chk("R3", "count at full", occ_count, 16);
      for (int i = 0; i < 17; i++) step(0, 8'h00, 1, 1, 1, 0, 8'h00, "R2");

      // R10: pops while empty
      for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 1, 1, 0, 8'h00, "R10");

      // R4: bytes offered with receive disabled
      for (int i = 0; i < 4; i++) step(1, 8'(8'hA0 + i), 0, 1, 0, 0, 8'h00, "R4");
      chk("R4", "count ignored", occ_count, 0);

      // R5 R6 R7 R8: sweep all codes, with and without interrupt enable
      for (int ie = 1; ie >= 0; ie--) begin
         for (int c = 0; c < 4; c++) begin
            step(0, 8'h00, 1, ie[0], 0, 1, {c[1:0], 6'b000010}, "R9");
            for (int i = 0; i < 17; i++) step(1, 8'(c * 32 + i), 1, ie[0], 0, 0, 8'h00, "R5");
            // R7: lowering the code does not re-evaluate the flag
            step(0, 8'h00, 1, ie[0], 0, 1, 8'h00, "R7");
            for (int i = 0; i < 17; i++) step(0, 8'h00, 1, ie[0], 1, 0, 8'h00, "R7");
         end
      end

      // R8: interrupt dropped when enable goes low while flag stays
      step(0, 8'h00, 1, 1, 0, 1, 8'h40, "R5");
      for (int i = 0; i < 5; i++) step(1, 8'(8'h70 + i), 1, 1, 0, 0, 8'h00, "R8");
      step(0, 8'h00, 1, 0, 0, 0, 8'h00, "R8");
      chk("R8", "irq masked", rx_irq, 0);
      chk("R8", "flag kept", data_full, 1);

      // R9: flush beats a same-cycle push and pop
      step(1, 8'hEE, 1, 1, 1, 1, 8'h02, "R9");
      chk("R9", "count after flush", occ_count, 0);

      // R11: push and pop together at several fill levels, including full and empty
      for (int lvl = 0; lvl <= 16; lvl += 4) begin
         step(0, 8'h00, 1, 1, 0, 1, 8'h82, "R9");
         for (int i = 0; i < lvl; i++) step(1, 8'(i + 1), 1, 1, 0, 0, 8'h00, "R2");
         for (int i = 0; i < 3; i++) step(1, 8'(8'hC0 + i), 1, 1, 1, 0, 8'h00, "R11");
      end

      // R12: move pointers mid-buffer, then fill across the wrap and drain
      step(0, 8'h00, 1, 1, 0, 1, 8'h02, "R9");
      for (int i = 0; i < 11; i++) step(1, 8'(i), 1, 1, 0, 0, 8'h00, "R2");
      for (int i = 0; i < 11; i++) step(0, 8'h00, 1, 1, 1, 0, 8'h00, "R2");
      for (int i = 0; i < 16; i++) step(1, 8'(8'h30 + i), 1, 1, 0, 0, 8'h00, "R12");
      for (int i = 0; i < 16; i++) step(0, 8'h00, 1, 1, 1, 0, 8'h00, "R12");

      // mixed pseudo-random traffic, all requirements against the model
      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[1] | lfsr[2] | lfsr[3],
              lfsr[4] | lfsr[6], lfsr[7] & ~lfsr[9] | lfsr[2] & lfsr[11],
              (lfsr[12:9] == 4'hF), {lfsr[14:13], 5'b0, lfsr[3], 1'b0} | {6'b0, lfsr[8] & lfsr[1], 1'b0},
              "R11");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog (run did not complete) actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule